// File: doc/BRIEF.md
# ADC Result Threshold Comparator

This block watches the stream of conversion results that leave an analog-to-digital converter and raises a flag when a chosen sample slot keeps meeting a threshold condition. Four compare units are provided. Each unit is tied to one source slot. It tests every result from that slot against a 12-bit threshold, either as "result below threshold" or as "result at or above threshold". A flag is raised only after the condition has held for a programmed number of results in a row from that slot. A single stray sample therefore cannot trip it.

The units come in pairs (0 with 1, 2 with 3). When a pair runs in window mode, the even unit counts only results that satisfy both its own condition and the odd unit's condition. Programming a low bound on one unit and a high bound on the other gives an in-band or out-of-band detector. Software clears flags by writing ones. One interrupt line combines every flag whose interrupt enable is set. The block does not store results.

Top module: `adc_result_comparator`

## Requirements
- R1: While synchronous reset (rst_n low) is applied at a clock edge, all four flags and the interrupt read 0 after that edge.
- R2: A unit's condition bit 0 selects "result < threshold" and bit 1 selects "result >= threshold". Both are unsigned 12-bit comparisons, so a result equal to the threshold matches only the second form.
- R3: The run-length field is 4 bits and holds the wanted consecutive count minus one. A flag sets on the clock edge that accepts the result completing that many consecutive matching results from the unit's slot. A field of 0 means every single matching result sets the flag.
- R4: A non-matching result from the unit's own slot restarts its run from zero. Results tagged with other slots, and cycles with res_valid low, leave the run unchanged.
- R5: The result that completes a run also restarts the run from zero. A cleared flag therefore sets again only after a fresh full run.
- R6: A 1 on flag_clr bit n clears flag n at the next edge. If a run completes on that same edge, the set wins and the flag stays 1. A flag with no clear request holds its value.
- R7: With a pair's window bit set (bit 0 for units 0 and 1, bit 1 for units 2 and 3), the even unit counts a result from its own slot as matching only when its condition holds, the odd unit is enabled, and the odd unit's condition and threshold also hold for that same result.
- R8: In window mode the odd unit still counts and flags on its own slot exactly as without window mode.
- R9: A unit whose enable is 0 never sets its flag and has its run held at zero. A flag it already holds stays set until cleared.
- R10: cmp_irq is 1 exactly when some flag is 1 and that unit's interrupt enable is 1. Flags set whether or not their interrupt is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | A new conversion result is present this cycle |
| res_slot | input | 5 | Sample slot (0 to 18) that produced the result |
| res_data | input | 12 | Conversion result, unsigned |
| cfg_enable | input | 4 | Per-unit enable, bit n for unit n |
| cfg_src_slot | input | 20 | Per-unit watched slot, unit n at bits [5n+4:5n] |
| cfg_cond_ge | input | 4 | Per-unit condition: 0 below threshold, 1 at or above |
| cfg_value | input | 48 | Per-unit threshold, unit n at bits [12n+11:12n] |
| cfg_run_m1 | input | 16 | Per-unit consecutive count minus one, unit n at bits [4n+3:4n] |
| cfg_pair_window | input | 2 | Window mode per pair, bit p for units 2p and 2p+1 |
| cfg_irq_en | input | 4 | Per-unit interrupt enable |
| flag_clr | input | 4 | Write-one-to-clear strobes for the flags |
| cmp_flag | output | 4 | Compare flags, bit n for unit n |
| cmp_irq | output | 1 | Combined compare interrupt request |

## Verification
The bench targets several edges of the block. It tests results exactly at the threshold in both condition forms, where an off-by-one comparison would flag one code early or late. It also checks runs broken by other slots' results or idle cycles, which a design that clears the run on any result would never finish. A clear request that lands on the same edge as a completing run would lose the event in a design that let clear win. Window pairs are tested with results that satisfy only one bound, which a design using the odd unit's own slot or ignoring its enable would flag wrongly. A seeded random phase with changing configurations then compares every cycle against a reference model, so a run counter that saturates instead of restarting shows up as early re-flagging.

// File: rtl/adc_cmp_pkg.sv
// Shared widths and types for the ADC result comparator.
// Assumes a result width of 12 bits, slot index of 5 bits and a
// 4-bit run-length field; all sub-blocks take their widths from here.
package adc_cmp_pkg;

    parameter int unsigned RES_W  = 12;  // conversion result width
    parameter int unsigned SLOT_W = 5;   // sample slot index width
    parameter int unsigned RUN_W  = 4;   // consecutive-count field width

    // Compare condition encoding, as seen on cfg_cond_ge.
    typedef enum logic {
        COND_BELOW   = 1'b0,
        COND_AT_OVER = 1'b1
    } cmp_cond_e;

    // Configuration of a single compare unit after unpacking.
    typedef struct packed {
        logic                  enable;
        logic [SLOT_W-1:0]     slot;
        cmp_cond_e             cond;
        logic [RES_W-1:0]      value;
        logic [RUN_W-1:0]      run_m1;
        logic                  irq_en;
    } unit_cfg_t;

endpackage

// File: rtl/adc_cmp_eval.sv
// Threshold evaluator: tells whether a result meets one unit's condition.
// Purely combinational; it does not look at slot or valid, so a result
// can be tested against any unit's threshold regardless of its source.
module adc_cmp_eval
    import adc_cmp_pkg::*;
(
    input  logic [RES_W-1:0] data,
    input  logic [RES_W-1:0] value,
    input  cmp_cond_e        cond,
    output logic             met
);

    logic below;

    // Unsigned magnitude test shared by both condition forms.
    always_comb begin
        below = (data < value);
    end

    // Pick the requested form of the condition.
    always_comb begin
        unique case (cond)
            COND_BELOW:   met = below;
            COND_AT_OVER: met = !below;
            default:      met = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_cmp_run.sv
// Consecutive-match run counter for one compare unit.
// Accepts a result only when it is valid and tagged with the unit's slot.
// A matching result either advances the run or, when it completes the
// programmed length, reports a hit and restarts the run at zero.
// A non-matching accepted result restarts the run. A disabled unit keeps
// its run at zero. Assumes run_m1 is stable while a run is in progress.
module adc_cmp_run
    import adc_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              res_valid,
    input  logic [SLOT_W-1:0] res_slot,
    input  logic [SLOT_W-1:0] watch_slot,
    input  logic              matched,
    input  logic [RUN_W-1:0]  run_m1,
    output logic              hit
);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;
    logic             accept;
    logic             at_end;

    // Decide whether this cycle's result belongs to the unit.
    always_comb begin
        accept = enable && res_valid && (res_slot == watch_slot);
        at_end = (run_q == run_m1);
    end

    // Next run length and hit pulse.
    always_comb begin
        run_d = run_q;
        hit   = 1'b0;
        if (!enable) begin
            run_d = '0;
        end else if (accept) begin
            if (!matched) begin
                run_d = '0;
            end else if (at_end) begin
                run_d = '0;
                hit   = 1'b1;
            end else begin
                run_d = run_q + RUN_W'(1);
            end
        end
    end

    // Run length register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/adc_cmp_flags.sv
// Compare flag bank with write-one-to-clear and the combined interrupt.
// A hit on the same edge as a clear request wins, so no event is lost.
module adc_cmp_flags #(
    parameter int unsigned NUM_UNITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] hit,
    input  logic [NUM_UNITS-1:0] clr,
    input  logic [NUM_UNITS-1:0] irq_en,
    output logic [NUM_UNITS-1:0] flag,
    output logic                 irq
);

    logic [NUM_UNITS-1:0] flag_q;

    // Hold, clear on request, set on hit (set has priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr) | hit;
        end
    end

    // Drive the flag outputs and merge enabled flags into one request.
    always_comb begin
        flag = flag_q;
        irq  = |(flag_q & irq_en);
    end

endmodule

// File: rtl/adc_result_comparator.sv
// ADC result threshold comparator: NUM_UNITS compare units, paired for
// window mode. Each unit evaluates its own threshold on every result; an
// even unit in window mode additionally requires its odd partner's
// condition on the same result. Run counters qualify results by slot.
// Assumes NUM_UNITS is even and configuration is changed only between runs.
module adc_result_comparator
    import adc_cmp_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 4,
    parameter int unsigned NUM_PAIRS = NUM_UNITS / 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         res_valid,
    input  logic [SLOT_W-1:0]            res_slot,
    input  logic [RES_W-1:0]             res_data,
    input  logic [NUM_UNITS-1:0]         cfg_enable,
    input  logic [NUM_UNITS*SLOT_W-1:0]  cfg_src_slot,
    input  logic [NUM_UNITS-1:0]         cfg_cond_ge,
    input  logic [NUM_UNITS*RES_W-1:0]   cfg_value,
    input  logic [NUM_UNITS*RUN_W-1:0]   cfg_run_m1,
    input  logic [NUM_PAIRS-1:0]         cfg_pair_window,
    input  logic [NUM_UNITS-1:0]         cfg_irq_en,
    input  logic [NUM_UNITS-1:0]         flag_clr,
    output logic [NUM_UNITS-1:0]         cmp_flag,
    output logic                         cmp_irq
);

    unit_cfg_t            ucfg  [NUM_UNITS];
    logic [NUM_UNITS-1:0] own_met;
    logic [NUM_UNITS-1:0] run_met;
    logic [NUM_UNITS-1:0] hit;
    logic [NUM_UNITS-1:0] irq_en_v;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        // Unpack this unit's fields from the flat configuration ports.
        always_comb begin
            ucfg[u].enable = cfg_enable[u];
            ucfg[u].slot   = cfg_src_slot[u*SLOT_W +: SLOT_W];
            ucfg[u].cond   = cmp_cond_e'(cfg_cond_ge[u]);
            ucfg[u].value  = cfg_value[u*RES_W +: RES_W];
            ucfg[u].run_m1 = cfg_run_m1[u*RUN_W +: RUN_W];
            ucfg[u].irq_en = cfg_irq_en[u];
            irq_en_v[u]    = ucfg[u].irq_en;
        end

        adc_cmp_eval u_eval (
            .data  (res_data),
            .value (ucfg[u].value),
            .cond  (ucfg[u].cond),
            .met   (own_met[u])
        );

        if ((u % 2) == 0) begin : g_even
            // Even unit: in window mode also needs the enabled partner's condition.
            always_comb begin
                if (cfg_pair_window[u/2]) begin
                    run_met[u] = own_met[u] && own_met[u+1] && ucfg[u+1].enable;
                end else begin
                    run_met[u] = own_met[u];
                end
            end
        end else begin : g_odd
            // Odd unit: always counts on its own condition.
            always_comb begin
                run_met[u] = own_met[u];
            end
        end

        adc_cmp_run u_run (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (ucfg[u].enable),
            .res_valid  (res_valid),
            .res_slot   (res_slot),
            .watch_slot (ucfg[u].slot),
            .matched    (run_met[u]),
            .run_m1     (ucfg[u].run_m1),
            .hit        (hit[u])
        );
    end

    adc_cmp_flags #(
        .NUM_UNITS (NUM_UNITS)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .clr    (flag_clr),
        .irq_en (irq_en_v),
        .flag   (cmp_flag),
        .irq    (cmp_irq)
    );

endmodule

// File: rtl/adc_result_comparator_chk.sv
// Property checker for the ADC result comparator, attached by bind.
// Observes ports only; every property is disabled while reset is low.
module adc_result_comparator_chk
    import adc_cmp_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 4,
    parameter int unsigned NUM_PAIRS = NUM_UNITS / 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         res_valid,
    input logic [SLOT_W-1:0]            res_slot,
    input logic [NUM_UNITS-1:0]         cfg_enable,
    input logic [NUM_UNITS*SLOT_W-1:0]  cfg_src_slot,
    input logic [NUM_UNITS-1:0]         cfg_cond_ge,
    input logic [NUM_UNITS*RES_W-1:0]   cfg_value,
    input logic [NUM_UNITS*RUN_W-1:0]   cfg_run_m1,
    input logic [NUM_PAIRS-1:0]         cfg_pair_window,
    input logic [NUM_UNITS-1:0]         flag_clr,
    input logic [NUM_UNITS-1:0]         cmp_flag,
    input logic                         cmp_irq
);

    // R10: an interrupt request needs at least one raised flag.
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> (|cmp_flag));

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
        // R4: a flag can only rise after a valid result from the unit's own slot.
        assert_rise_from_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cmp_flag[u]) |->
                $past(res_valid && (res_slot == cfg_src_slot[u*SLOT_W +: SLOT_W])));

        // R9: a disabled unit never raises its flag.
        assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_enable[u] |=> !$rose(cmp_flag[u]));

        // R6: a flag without a clear request stays set.
        assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_flag[u] && !flag_clr[u]) |=> cmp_flag[u]);

        // R6: a clear with no result from the unit's slot leaves the flag low.
        assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[u] && !(res_valid &&
                (res_slot == cfg_src_slot[u*SLOT_W +: SLOT_W]))) |=> !cmp_flag[u]);

        // R3: run length one, ">= 0" always matches, so one result sets the flag.
        if ((u % 2) == 1) begin : g_single
            assert_single_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_enable[u] && cfg_cond_ge[u] && (cfg_value[u*RES_W +: RES_W] == '0) &&
                 (cfg_run_m1[u*RUN_W +: RUN_W] == '0) && res_valid &&
                 (res_slot == cfg_src_slot[u*SLOT_W +: SLOT_W])) |=> cmp_flag[u]);
        end else begin : g_single_even
            assert_single_run_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_enable[u] && !cfg_pair_window[u/2] && cfg_cond_ge[u] &&
                 (cfg_value[u*RES_W +: RES_W] == '0) &&
                 (cfg_run_m1[u*RUN_W +: RUN_W] == '0) && res_valid &&
                 (res_slot == cfg_src_slot[u*SLOT_W +: SLOT_W])) |=> cmp_flag[u]);
        end
    end

endmodule

bind adc_result_comparator adc_result_comparator_chk #(
    .NUM_UNITS (NUM_UNITS),
    .NUM_PAIRS (NUM_PAIRS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .res_valid       (res_valid),
    .res_slot        (res_slot),
    .cfg_enable      (cfg_enable),
    .cfg_src_slot    (cfg_src_slot),
    .cfg_cond_ge     (cfg_cond_ge),
    .cfg_value       (cfg_value),
    .cfg_run_m1      (cfg_run_m1),
    .cfg_pair_window (cfg_pair_window),
    .flag_clr        (flag_clr),
    .cmp_flag        (cmp_flag),
    .cmp_irq         (cmp_irq)
);

// File: tb/adc_result_comparator_tb.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared every cycle against a reference model written from the brief.
module adc_result_comparator_tb;

    localparam int N  = 4;
    localparam int SW = 5;
    localparam int RW = 12;
    localparam int MW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            res_valid;
    logic [SW-1:0]   res_slot;
    logic [RW-1:0]   res_data;
    logic [N-1:0]    cfg_enable;
    logic [N*SW-1:0] cfg_src_slot;
    logic [N-1:0]    cfg_cond_ge;
    logic [N*RW-1:0] cfg_value;
    logic [N*MW-1:0] cfg_run_m1;
    logic [N/2-1:0]  cfg_pair_window;
    logic [N-1:0]    cfg_irq_en;
    logic [N-1:0]    flag_clr;
    logic [N-1:0]    cmp_flag;
    logic            cmp_irq;

    int total = 0;
    int bad   = 0;
    int       m_run  [N];
    logic [N-1:0] m_flag;

    always #4 clk = ~clk;

    adc_result_comparator u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
        .res_data(res_data), .cfg_enable(cfg_enable), .cfg_src_slot(cfg_src_slot),
        .cfg_cond_ge(cfg_cond_ge), .cfg_value(cfg_value), .cfg_run_m1(cfg_run_m1),
        .cfg_pair_window(cfg_pair_window), .cfg_irq_en(cfg_irq_en),
        .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic cond_ok(input int u, input logic [RW-1:0] d);
        logic [RW-1:0] v;
        v = cfg_value[u*RW +: RW];
        return cfg_cond_ge[u] ? (d >= v) : (d < v);
    endfunction

    // Reference model of one clock edge, from R2 to R9.
    task automatic model_edge();
        logic [N-1:0] hitv;
        hitv = '0;
        for (int u = 0; u < N; u++) begin
            logic take, ok;
            take = cfg_enable[u] && res_valid && (res_slot == cfg_src_slot[u*SW +: SW]);
            ok = cond_ok(u, res_data);
            if ((u % 2 == 0) && cfg_pair_window[u/2])
                ok = ok && cfg_enable[u+1] && cond_ok(u+1, res_data);
            if (!cfg_enable[u]) m_run[u] = 0;
            else if (take) begin
                if (!ok) m_run[u] = 0;
                else if (m_run[u] == int'(cfg_run_m1[u*MW +: MW])) begin
                    m_run[u] = 0;
                    hitv[u] = 1'b1;
                end else m_run[u]++;
            end
        end
        m_flag = (m_flag & ~flag_clr) | hitv;
    endtask

    // Drive one cycle at the falling edge, clock it, check at the next falling edge.
    task automatic step(input string tag, input logic v, input int slot,
                        input int data, input logic [N-1:0] clr);
        res_valid = v;
        res_slot  = SW'(slot);
        res_data  = RW'(data);
        flag_clr  = clr;
        model_edge();
        @(negedge clk);
        chk({tag, " flags"}, 32'(cmp_flag), 32'(m_flag));
        chk("R10 irq", 32'(cmp_irq), 32'(|(m_flag & cfg_irq_en)));
        res_valid = 1'b0;
        flag_clr  = '0;
    endtask

    task automatic set_unit(input int u, input logic en, input int slot, input logic ge,
                            input int value, input int m1);
        cfg_enable[u]             = en;
        cfg_src_slot[u*SW +: SW]  = SW'(slot);
        cfg_cond_ge[u]            = ge;
        cfg_value[u*RW +: RW]     = RW'(value);
        cfg_run_m1[u*MW +: MW]    = MW'(m1);
    endtask

    task automatic clear_all();
        step("R6 clear", 1'b0, 0, 0, '1);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; res_valid = 1'b0; res_slot = '0; res_data = '0;
        cfg_enable = '0; cfg_src_slot = '0; cfg_cond_ge = '0; cfg_value = '0;
        cfg_run_m1 = '0; cfg_pair_window = '0; cfg_irq_en = '0; flag_clr = '0;
        m_flag = '0;
        for (int u = 0; u < N; u++) m_run[u] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset flags", 32'(cmp_flag), 32'h0);
        chk("R1 reset irq", 32'(cmp_irq), 32'h0);
        rst_n = 1'b1;

        // R3: ten results in a row at or above 0x800 on slot 5.
        set_unit(1, 1'b1, 5, 1'b1, 'h800, 9);
        for (int k = 0; k < 9; k++) step("R3 run", 1'b1, 5, 'h800 + k, '0);
        chk("R3 not yet", 32'(cmp_flag), 32'h0);
        step("R3 tenth", 1'b1, 5, 'hFFF, '0);
        chk("R3 tenth sets", 32'(cmp_flag), 32'h2);
        clear_all();

        // R4: other slots and idle cycles do not break a run; a miss does.
        set_unit(1, 1'b1, 5, 1'b1, 'h800, 2);
        step("R4", 1'b1, 5, 'h900, '0);
        step("R4", 1'b1, 5, 'h900, '0);
        step("R4 other slot", 1'b1, 6, 'h100, '0);
        step("R4 idle", 1'b0, 5, 'h100, '0);
        step("R4 completes", 1'b1, 5, 'h900, '0);
        chk("R4 run survives", 32'(cmp_flag), 32'h2);
        clear_all();
        step("R4", 1'b1, 5, 'h900, '0);
        step("R4", 1'b1, 5, 'h900, '0);
        step("R4 miss", 1'b1, 5, 'h7FF, '0);
        step("R4", 1'b1, 5, 'h900, '0);
        step("R4", 1'b1, 5, 'h900, '0);
        chk("R4 miss restarts", 32'(cmp_flag), 32'h0);
        step("R4", 1'b1, 5, 'h900, '0);
        chk("R4 fresh run", 32'(cmp_flag), 32'h2);
        clear_all();
        set_unit(1, 1'b0, 0, 1'b0, 0, 0);

        // R2: boundary of both condition forms.
        set_unit(0, 1'b1, 2, 1'b0, 'h100, 0);
        step("R2 lt equal", 1'b1, 2, 'h100, '0);
        chk("R2 equal not below", 32'(cmp_flag[0]), 32'h0);
        step("R2 lt below", 1'b1, 2, 'h0FF, '0);
        chk("R2 below matches", 32'(cmp_flag[0]), 32'h1);
        clear_all();
        set_unit(0, 1'b1, 2, 1'b1, 'h100, 0);
        step("R2 ge below", 1'b1, 2, 'h0FF, '0);
        chk("R2 below fails ge", 32'(cmp_flag[0]), 32'h0);
        step("R2 ge equal", 1'b1, 2, 'h100, '0);
        chk("R2 equal meets ge", 32'(cmp_flag[0]), 32'h1);

        // R6: set wins over a same-edge clear; a lone clear clears.
        step("R6 clr+hit", 1'b1, 2, 'h200, 4'b0001);
        chk("R6 set wins", 32'(cmp_flag[0]), 32'h1);
        step("R6 clr", 1'b0, 2, 'h200, 4'b0001);
        chk("R6 cleared", 32'(cmp_flag[0]), 32'h0);

        // R5: after a completed run, a new full run is needed.
        set_unit(0, 1'b1, 2, 1'b1, 'h100, 1);
        step("R5", 1'b1, 2, 'h200, '0);
        step("R5 complete", 1'b1, 2, 'h200, '0);
        chk("R5 first run", 32'(cmp_flag[0]), 32'h1);
        step("R5 clr", 1'b0, 2, 0, 4'b0001);
        step("R5 one more", 1'b1, 2, 'h200, '0);
        chk("R5 restarted", 32'(cmp_flag[0]), 32'h0);
        step("R5 second", 1'b1, 2, 'h200, '0);
        chk("R5 second run", 32'(cmp_flag[0]), 32'h1);
        clear_all();

        // R7/R8: window on pair 0, band 0x400..0xBFF; odd unit on its own slot 9.
        set_unit(0, 1'b1, 3, 1'b1, 'h400, 0);
        set_unit(1, 1'b1, 9, 1'b0, 'hC00, 0);
        cfg_pair_window = 2'b01;
        step("R7 in band", 1'b1, 3, 'h800, '0);
        chk("R7 both bounds", 32'(cmp_flag[1:0]), 32'h1);
        clear_all();
        step("R7 above band", 1'b1, 3, 'hD00, '0);
        chk("R7 only low bound", 32'(cmp_flag[1:0]), 32'h0);
        step("R8 odd own slot", 1'b1, 9, 'h100, '0);
        chk("R8 odd independent", 32'(cmp_flag[1:0]), 32'h2);
        clear_all();
        cfg_enable[1] = 1'b0;
        step("R7 partner off", 1'b1, 3, 'h800, '0);
        chk("R7 needs partner", 32'(cmp_flag[1:0]), 32'h0);
        cfg_pair_window = 2'b00;

        // R9: disabled unit stays quiet but keeps a held flag.
        set_unit(2, 1'b1, 4, 1'b1, 0, 0);
        step("R9 set", 1'b1, 4, 5, '0);
        cfg_enable[2] = 1'b0;
        step("R9 disabled", 1'b1, 4, 5, '0);
        chk("R9 held flag", 32'(cmp_flag[2]), 32'h1);
        step("R9 clr", 1'b0, 4, 5, 4'b0100);
        step("R9 disabled again", 1'b1, 4, 5, '0);
        chk("R9 no set", 32'(cmp_flag[2]), 32'h0);

        // R10: interrupt follows enabled flags only.
        set_unit(3, 1'b1, 7, 1'b1, 0, 0);
        step("R10 set", 1'b1, 7, 1, '0);
        chk("R10 masked", 32'(cmp_irq), 32'h0);
        cfg_irq_en = 4'b1000;
        #1;
        chk("R10 enabled", 32'(cmp_irq), 32'h1);
        clear_all();

        // Random phase: all rules (R2..R10) against the model.
        for (int blk = 0; blk < 15; blk++) begin
            for (int u = 0; u < N; u++)
                set_unit(u, ($urandom % 5) != 0, $urandom % 4, $urandom % 2,
                         $urandom % 4096, $urandom % 4);
            cfg_pair_window = 2'($urandom);
            cfg_irq_en      = 4'($urandom);
            for (int k = 0; k < 200; k++)
                step("R3 random", ($urandom % 4) != 0, ($urandom % 5 == 4) ? 18 : $urandom % 4,
                     $urandom % 4096, (($urandom % 8) == 0) ? 4'($urandom) : 4'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule